// File: doc/BRIEF.md
# Dual Comparator Mode and Routing Controller

This block is the digital control side of a two-comparator peripheral. It holds a small control register and turns a 3-bit mode code, an input-switch bit and two inversion bits into everything the analog side and the port logic need. These are the select lines of each comparator's negative and positive input multiplexers, a power enable per comparator, and a flag that marks the on-chip reference as a comparator input. It also produces overrides that put comparator results straight onto two port pins, and a mask that forces port reads of analog-configured pins to zero.

The comparators themselves are outside the block. For every input pairing a comparator could be given, a digital result bit comes in. The block picks the bit that matches the current selects, applies the inversion and gates it with the enable. The result appears in the top two bits of the register read value and, in the routing modes, on pins 3 and 4. Port direction control stays outside, so driver enables never pass through this block.

Top module: `cmp_route_ctrl`

## Requirements
- R1: A synchronous reset clears the register to 0x00. After reset, both comparators are disabled, every select output is 0, and port reads of pins 0 to 3 return 0.
- R2: A write stores wr_data[5:0] as {invert 2, invert 1, switch, mode[2:0]}. Bits 7:6 of the written value are ignored. rd_data[5:0] returns the stored bits from the cycle after the write.
- R3: rd_data[6] is comparator 1's output and rd_data[7] is comparator 2's output. An enabled comparator outputs its result bit at index {pos_sel, neg_sel}, XORed with its invert bit.
- R4: In modes 000 and 111, both comparators are disabled. In mode 101, only comparator 2 is enabled. A disabled comparator outputs 0 whatever its invert bit is, and its select lines are parked at 0.
- R5: In mode 001, comparator 1 takes neg_sel = switch (0 selects pin 0, 1 selects pin 3) and pos_sel = 01 (pin 2). Comparator 2 takes neg_sel = 0 (pin 1) and pos_sel = 01.
- R6: In mode 010, both negative selects equal the switch bit (comparator 1: pin 0 or pin 3, comparator 2: pin 1 or pin 2) and both pos_sel = 10 (internal reference). vref_sel is 1 in this mode and 0 in every other mode.
- R7: In modes 011 and 110, both comparators use neg_sel = 0 and pos_sel = 01. In mode 100, comparator 1 uses pos_sel = 00 (pin 3) and comparator 2 uses pos_sel = 01. Mode 101 gives comparator 2 neg_sel = 0 and pos_sel = 01.
- R8: Outside modes 001 and 010, the switch bit has no effect on any select, enable or output.
- R9: In modes 001 and 110, pin_dout[3] carries comparator 1's output and pin_dout[4] carries comparator 2's output. In all other modes, pin_dout equals latch_dout. pin_dout[2:0] always equals latch_dout[2:0].
- R10: port_rd[i] = pin_in[i] unless pin i is analog in the current mode. Pins 0 to 3 are all analog in modes 000, 001, 010 and 100. Pins 0 to 2 are analog in modes 011 and 110. Pins 1 and 2 are analog in mode 101. No pin is analog in mode 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value (bits 7:6 ignored) |
| rd_data | output | 8 | Register read value with live outputs in 7:6 |
| res_c1 | input | 8 | Comparator 1 result for each pairing, index {pos_sel, neg_sel} |
| res_c2 | input | 8 | Comparator 2 result for each pairing, index {pos_sel, neg_sel} |
| cmp_en | output | 2 | Power enable, bit 0 comparator 1, bit 1 comparator 2 |
| neg_sel | output | 2 | Negative input select per comparator (0 primary, 1 alternate) |
| pos_sel_c1 | output | 2 | Comparator 1 positive select (00 pin 3, 01 pin 2, 10 reference) |
| pos_sel_c2 | output | 2 | Comparator 2 positive select (01 pin 2, 10 reference) |
| vref_sel | output | 1 | Internal reference feeds the comparators |
| latch_dout | input | 5 | Port data latch for pins 0 to 4 |
| pin_dout | output | 5 | Pin data after comparator override |
| pin_in | input | 4 | Digital pad values of pins 0 to 3 |
| port_rd | output | 4 | Port read value with analog pins forced to 0 |

## Verification
The bench walks every mode with both switch values and all four inversion settings, and each write also sets bits 7:6. That separates the modes that use the switch from those that must ignore it, and it shows that the read-only bits are never stored. For every configuration, a one-hot result pattern is walked across all eight pairing indices. Only the pairing named by the selects may move an output, so a wrong select, a wrong index order or a missed inversion each gives a distinct mismatch on the read bits and on pins 3 and 4. All pads are held high while the latch alternates between two patterns, so the analog mask of each mode and the presence or absence of a pin override both show up directly.

// File: rtl/cmp_route_pkg.sv
package cmp_route_pkg;

    localparam int NUM_CMP   = 2;
    localparam int MODE_W    = 3;
    localparam int POS_W     = 2;
    localparam int RES_W     = 1 << (POS_W + 1);
    localparam int CFG_W     = 6;
    localparam int REG_W     = CFG_W + NUM_CMP;
    localparam int ANA_PINS  = 4;
    localparam int PORT_PINS = 5;
    localparam int OVR_BASE  = 3;

    typedef enum logic [MODE_W-1:0] {
        M_RESET   = 3'b000,
        M_MUX3    = 3'b001,
        M_MUX4REF = 3'b010,
        M_COMMON  = 3'b011,
        M_INDEP   = 3'b100,
        M_SINGLE  = 3'b101,
        M_COMOUT  = 3'b110,
        M_OFF     = 3'b111
    } cmp_mode_e;

    typedef enum logic [POS_W-1:0] {
        POS_PIN3 = 2'b00,
        POS_PIN2 = 2'b01,
        POS_VREF = 2'b10
    } pos_sel_e;

    typedef struct packed {
        logic      inv2;
        logic      inv1;
        logic      sw;
        cmp_mode_e mode;
    } cfg_t;

    typedef struct packed {
        logic [NUM_CMP-1:0]  en;
        logic [NUM_CMP-1:0]  neg;
        pos_sel_e            pos2;
        pos_sel_e            pos1;
        logic                vref;
        logic                route;
        logic [ANA_PINS-1:0] analog;
    } route_t;

    function automatic logic [POS_W:0] pair_index(input pos_sel_e p, input logic n);
        return {p, n};
    endfunction

endpackage

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
    import cmp_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output cfg_t                cfg
);
    logic unused_ro_bits;
    assign unused_ro_bits = ^wr_data[REG_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (wr_en)
            cfg <= cfg_t'(wr_data[CFG_W-1:0]);
    end

    // R2: only the low field is captured
    p_wr_lowbits_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg == cfg_t'($past(wr_data[CFG_W-1:0]))));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));
endmodule

// File: rtl/cmp_mode_dec.sv
module cmp_mode_dec
    import cmp_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmp_mode_e mode,
    input  logic      sw,
    output route_t    rt
);
    always_comb begin
        rt        = '0;
        rt.pos1   = POS_PIN3;
        rt.pos2   = POS_PIN3;
        unique case (mode)
            M_RESET: begin
                rt.analog = 4'b1111;
            end
            M_MUX3: begin
                rt.en     = 2'b11;
                rt.neg[0] = sw;
                rt.pos1   = POS_PIN2;
                rt.pos2   = POS_PIN2;
                rt.route  = 1'b1;
                rt.analog = 4'b1111;
            end
            M_MUX4REF: begin
                rt.en     = 2'b11;
                rt.neg    = {sw, sw};
                rt.pos1   = POS_VREF;
                rt.pos2   = POS_VREF;
                rt.vref   = 1'b1;
                rt.analog = 4'b1111;
            end
            M_COMMON: begin
                rt.en     = 2'b11;
                rt.pos1   = POS_PIN2;
                rt.pos2   = POS_PIN2;
                rt.analog = 4'b0111;
            end
            M_INDEP: begin
                rt.en     = 2'b11;
                rt.pos1   = POS_PIN3;
                rt.pos2   = POS_PIN2;
                rt.analog = 4'b1111;
            end
            M_SINGLE: begin
                rt.en     = 2'b10;
                rt.pos2   = POS_PIN2;
                rt.analog = 4'b0110;
            end
            M_COMOUT: begin
                rt.en     = 2'b11;
                rt.pos1   = POS_PIN2;
                rt.pos2   = POS_PIN2;
                rt.route  = 1'b1;
                rt.analog = 4'b0111;
            end
            default: begin
                rt.analog = 4'b0000;
            end
        endcase
    end

    // R4: off modes power nothing down the line
    p_off_modes_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RESET || mode == M_OFF) |-> (rt.en == '0));
    // R6: reference only in the four-input mode
    p_vref_only_r6: assert property (@(posedge clk) disable iff (rst)
        rt.vref |-> (mode == M_MUX4REF && rt.pos1 == POS_VREF && rt.pos2 == POS_VREF));
    // R8: switch is not observed outside the two switched modes
    p_sw_park_r8: assert property (@(posedge clk) disable iff (rst)
        (mode != M_MUX3 && mode != M_MUX4REF) |-> (rt.neg == '0));
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
    import cmp_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             inv,
    input  pos_sel_e         pos,
    input  logic             neg,
    input  logic [RES_W-1:0] res,
    output logic             out
);
    logic             picked;
    logic [POS_W:0]   idx;

    assign idx    = pair_index(pos, neg);
    assign picked = res[idx];
    assign out    = en & (picked ^ inv);

    // R4: disabled channel stays low
    p_off_low_r4: assert property (@(posedge clk) disable iff (rst)
        !en |-> !out);
    // R3: an unselected pairing changing alone cannot move the output
    p_sel_only_r3: assert property (@(posedge clk) disable iff (rst)
        ($stable(res[idx]) && $stable(en) && $stable(inv) && $stable(idx)) |-> $stable(out));
endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
    import cmp_route_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 route,
    input  logic [ANA_PINS-1:0]  analog,
    input  logic [NUM_CMP-1:0]   cout,
    input  logic [PORT_PINS-1:0] latch_dout,
    input  logic [ANA_PINS-1:0]  pin_in,
    output logic [PORT_PINS-1:0] pin_dout,
    output logic [ANA_PINS-1:0]  port_rd
);
    genvar gp;
    generate
        for (gp = 0; gp < PORT_PINS; gp++) begin : g_out
            if (gp >= OVR_BASE && gp < OVR_BASE + NUM_CMP) begin : g_ovr
                assign pin_dout[gp] = route ? cout[gp-OVR_BASE] : latch_dout[gp];
            end else begin : g_pass
                assign pin_dout[gp] = latch_dout[gp];
            end
        end
        for (gp = 0; gp < ANA_PINS; gp++) begin : g_rd
            assign port_rd[gp] = pin_in[gp] & ~analog[gp];
        end
    endgenerate

    // R9: no override when routing is off
    p_pass_r9: assert property (@(posedge clk) disable iff (rst)
        !route |-> (pin_dout == latch_dout));
    // R10: analog pins read zero
    p_mask_r10: assert property (@(posedge clk) disable iff (rst)
        ((port_rd & analog) == '0));
endmodule

// File: rtl/cmp_route_ctrl.sv
module cmp_route_ctrl
    import cmp_route_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [7:0]             wr_data,
    output logic [7:0]             rd_data,
    input  logic [7:0]             res_c1,
    input  logic [7:0]             res_c2,
    output logic [1:0]             cmp_en,
    output logic [1:0]             neg_sel,
    output logic [1:0]             pos_sel_c1,
    output logic [1:0]             pos_sel_c2,
    output logic                   vref_sel,
    input  logic [4:0]             latch_dout,
    output logic [4:0]             pin_dout,
    input  logic [3:0]             pin_in,
    output logic [3:0]             port_rd
);
    cfg_t               cfg;
    route_t             rt;
    logic [NUM_CMP-1:0] cout;
    logic [NUM_CMP-1:0] inv_v;
    logic [RES_W-1:0]   res_arr [NUM_CMP];
    pos_sel_e           pos_arr [NUM_CMP];

    cmp_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    cmp_mode_dec u_dec (
        .clk  (clk),
        .rst  (rst),
        .mode (cfg.mode),
        .sw   (cfg.sw),
        .rt   (rt)
    );

    assign res_arr[0] = res_c1;
    assign res_arr[1] = res_c2;
    assign pos_arr[0] = rt.pos1;
    assign pos_arr[1] = rt.pos2;
    assign inv_v      = {cfg.inv2, cfg.inv1};

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CMP; gc++) begin : g_ch
            cmp_channel u_ch (
                .clk (clk),
                .rst (rst),
                .en  (rt.en[gc]),
                .inv (inv_v[gc]),
                .pos (pos_arr[gc]),
                .neg (rt.neg[gc]),
                .res (res_arr[gc]),
                .out (cout[gc])
            );
        end
    endgenerate

    cmp_pin_mux u_pins (
        .clk        (clk),
        .rst        (rst),
        .route      (rt.route),
        .analog     (rt.analog),
        .cout       (cout),
        .latch_dout (latch_dout),
        .pin_in     (pin_in),
        .pin_dout   (pin_dout),
        .port_rd    (port_rd)
    );

    assign rd_data    = {cout[1], cout[0], cfg};
    assign cmp_en     = rt.en;
    assign neg_sel    = rt.neg;
    assign pos_sel_c1 = rt.pos1;
    assign pos_sel_c2 = rt.pos2;
    assign vref_sel   = rt.vref;

    // R1: reset leaves a zero register and no active comparator
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00 && cmp_en == 2'b00));
    // R4: off mode reads zero outputs
    p_off_read_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_data[2:0] == 3'b111) |-> (rd_data[7:6] == 2'b00));
    // R9: routed pins follow the register's output bits
    p_route_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_data[2:0] == 3'b001 || rd_data[2:0] == 3'b110) |-> (pin_dout[4:3] == rd_data[7:6]));
    // R10: reset mode reads every comparator pin as zero
    p_reset_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_data[2:0] == 3'b000) |-> (port_rd == 4'b0000));
endmodule

// File: tb/sim_cmp_route_ctrl.sv
`timescale 1ns/1ps
module sim_cmp_route_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [7:0] res_c1, res_c2;
    logic [1:0] cmp_en, neg_sel, pos_sel_c1, pos_sel_c2;
    logic       vref_sel;
    logic [4:0] latch_dout, pin_dout;
    logic [3:0] pin_in, port_rd;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cmp_route_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .res_c1(res_c1), .res_c2(res_c2), .cmp_en(cmp_en), .neg_sel(neg_sel),
        .pos_sel_c1(pos_sel_c1), .pos_sel_c2(pos_sel_c2), .vref_sel(vref_sel),
        .latch_dout(latch_dout), .pin_dout(pin_dout), .pin_in(pin_in), .port_rd(port_rd)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected routing from the requirement tables
    task automatic expect_mode(input int m, input logic sw,
        output logic [1:0] en, output logic [1:0] ng, output logic [1:0] p1,
        output logic [1:0] p2, output logic vr, output logic rt, output logic [3:0] an);
        en = 2'b00; ng = 2'b00; p1 = 2'b00; p2 = 2'b00; vr = 1'b0; rt = 1'b0; an = 4'b0000;
        case (m)
            0: an = 4'b1111;
            1: begin en = 2'b11; ng = {1'b0, sw}; p1 = 2'b01; p2 = 2'b01; rt = 1'b1; an = 4'b1111; end
            2: begin en = 2'b11; ng = {sw, sw}; p1 = 2'b10; p2 = 2'b10; vr = 1'b1; an = 4'b1111; end
            3: begin en = 2'b11; p1 = 2'b01; p2 = 2'b01; an = 4'b0111; end
            4: begin en = 2'b11; p1 = 2'b00; p2 = 2'b01; an = 4'b1111; end
            5: begin en = 2'b10; p2 = 2'b01; an = 4'b0110; end
            6: begin en = 2'b11; p1 = 2'b01; p2 = 2'b01; rt = 1'b1; an = 4'b0111; end
            default: ;
        endcase
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    initial begin
        #(200000 * 5.0);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] e_en, e_ng, e_p1, e_p2;
        logic       e_vr, e_rt;
        logic [3:0] e_an;
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        res_c1 = 8'hFF; res_c2 = 8'hFF; latch_dout = 5'b10101; pin_in = 4'hF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 rd_data", {8'h0, rd_data}, 16'h0000);
        chk("R1 enables/selects", {6'h0, cmp_en, neg_sel, pos_sel_c1, pos_sel_c2, vref_sel, 1'b0}, 16'h0);
        chk("R1 port read", {12'h0, port_rd}, 16'h0);

        for (int m = 0; m < 8; m++) begin
            for (int sw = 0; sw < 2; sw++) begin
                for (int iv = 0; iv < 4; iv++) begin
                    logic [7:0] wv;
                    wv = {2'b11, iv[1:0], sw[0], m[2:0]};
                    write_reg(wv);
                    #1;
                    expect_mode(m, sw[0], e_en, e_ng, e_p1, e_p2, e_vr, e_rt, e_an);
                    chk("R2 stored bits", {10'h0, rd_data[5:0]}, {10'h0, wv[5:0]});
                    chk("R4 enables", {14'h0, cmp_en}, {14'h0, e_en});
                    chk("R5/R6/R7/R8 neg selects", {14'h0, neg_sel}, {14'h0, e_ng});
                    chk("R5/R6/R7 pos selects", {12'h0, pos_sel_c1, pos_sel_c2}, {12'h0, e_p1, e_p2});
                    chk("R6 vref_sel", {15'h0, vref_sel}, {15'h0, e_vr});
                    for (int k = 0; k < 8; k++) begin
                        logic [1:0] eo;
                        logic [4:0] ep;
                        @(negedge clk);
                        res_c1 = 8'(1 << k);
                        res_c2 = 8'(1 << k);
                        latch_dout = k[0] ? 5'b10101 : 5'b01010;
                        pin_in = 4'hF;
                        #1;
                        eo[0] = e_en[0] & ((int'({e_p1, e_ng[0]}) == k) ^ iv[0]);
                        eo[1] = e_en[1] & ((int'({e_p2, e_ng[1]}) == k) ^ iv[1]);
                        chk("R3 outputs", {14'h0, rd_data[7:6]}, {14'h0, eo[1], eo[0]});
                        ep = e_rt ? {eo[1], eo[0], latch_dout[2:0]} : latch_dout;
                        chk("R9 pin data", {11'h0, pin_dout}, {11'h0, ep});
                        chk("R10 port read", {12'h0, port_rd}, {12'h0, pin_in & ~e_an});
                    end
                end
            end
        end

        // R1 reset mid-run from a busy configuration
        write_reg(8'b00110100);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 rd_data after reset", {8'h0, rd_data}, 16'h0000);
        chk("R1 enables after reset", {14'h0, cmp_en}, 16'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule